// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block times the release of a chip's reset. It watches an active-low power-on reset input. When that input has been low long enough and is then released, the block captures the mode straps and runs through a chain of timed phases. These are a configuration phase, a modelled PLL lock wait and an optional modelled DLL lock wait. After them come a hold period on the hard reset and a short extra hold on the soft reset. Both reset outputs stay low through every phase until their own release point.

Lock is modelled by counters and not measured. The configuration phase and the PLL wait count reference clocks; the PLL wait uses a configurable pre-divider. The DLL wait and both release holds count bus clocks, given as a clock enable. A DLL-disable input, captured with the straps, removes the DLL wait entirely. Pulling the power-on reset low at any moment drops both resets and returns the block to idle.

Top module: `por_reset_seq`

## Requirements
- R1: While `por_n` is low, `hreset_n` and `sreset_n` are low in that same cycle, and `phase` reads idle (code 0) after the next clock edge, whatever phase was active.
- R2: A low pulse on `por_n` is accepted only if it covers at least 16 rising clock edges. A shorter pulse leaves the block idle with both resets low, and the latched strap outputs keep their earlier values.
- R3: On an accepted release, `cfg_sel`, `modck[2:0]` and `dll_dis` are captured into `cfg_master`, `modck_q` and `dll_off`. These outputs then stay unchanged until the next accepted release.
- R4: The configuration phase (code 1) begins on the clock edge that sees `por_n` high and lasts exactly 1024 reference clocks.
- R5: The PLL wait (code 2) lasts 800 ticks of the pre-divided reference (800 clocks with the default divider of 1). `pll_locked` is high in every later phase.
- R6: With `dll_off` low, a DLL wait (code 3) of 3073 bus clocks follows the PLL wait. With `dll_off` high, the PLL wait leads directly to the hard-release hold (code 4). `dll_locked` is high from code 4 onward.
- R7: `hreset_n` goes high after 512 bus clocks in the hard-release hold, as the block enters the soft-release hold (code 5).
- R8: `sreset_n` goes high three bus clocks after `hreset_n`, as the block enters done (code 6). `sreset_n` is never high while `hreset_n` is low.
- R9: The DLL wait and both release holds advance only on cycles with `bus_ce` high. While `bus_ce` is low, neither the phase nor its count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| bus_ce | input | 1 | Bus-clock enable; one bus clock per high cycle |
| por_n | input | 1 | Power-on reset, active low |
| cfg_sel | input | 1 | Configuration-select strap (1 = configuration master) |
| modck | input | 3 | Clock-mode straps |
| dll_dis | input | 1 | DLL-disable bit of the configuration word |
| hreset_n | output | 1 | Hard reset, active low |
| sreset_n | output | 1 | Soft reset, active low |
| cfg_master | output | 1 | Latched configuration-select strap |
| modck_q | output | 3 | Latched clock-mode straps |
| dll_off | output | 1 | Latched DLL-disable bit |
| pll_locked | output | 1 | PLL wait completed |
| dll_locked | output | 1 | DLL wait completed or bypassed |
| phase | output | 3 | Phase code 0..6: idle, config, PLL, DLL, hard hold, soft hold, done |

## Verification
The assertions check several properties on every cycle. A rejected short pulse keeps the block idle. The latched straps do not move outside idle. The DLL wait is skipped when its disable bit is set. The hard reset is only ever released out of the hard-release hold. The soft reset never leads the hard reset. A low `bus_ce` freezes the bus-clock phases. Only the bench scenarios can show the exact length of each phase: they count the cycles to every phase boundary and to both reset releases. They also show the 15- versus 16-cycle acceptance boundary and the six-cycle soft-reset gap when `bus_ce` runs at half rate. An abort in the middle of a sequence is checked the same way.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CFG  = 3'd1,
    PH_PLL  = 3'd2,
    PH_DLL  = 3'd3,
    PH_HREL = 3'd4,
    PH_SREL = 3'd5,
    PH_DONE = 3'd6
  } phase_e;

  // Number of steps a phase takes before it hands over.
  function automatic int unsigned phase_len(phase_e ph, int unsigned cfg_len,
                                            int unsigned pll_len, int unsigned dll_len,
                                            int unsigned hrel_len, int unsigned srel_len);
    case (ph)
      PH_CFG:  return cfg_len;
      PH_PLL:  return pll_len;
      PH_DLL:  return dll_len;
      PH_HREL: return hrel_len;
      PH_SREL: return srel_len;
      default: return 1;
    endcase
  endfunction

  // Successor phase; the DLL wait drops out when bypassed.
  function automatic phase_e phase_next(phase_e ph, logic skip_dll);
    case (ph)
      PH_CFG:  return PH_PLL;
      PH_PLL:  return skip_dll ? PH_HREL : PH_DLL;
      PH_DLL:  return PH_HREL;
      PH_HREL: return PH_SREL;
      PH_SREL: return PH_DONE;
      default: return ph;
    endcase
  endfunction

  function automatic logic is_bus_phase(phase_e ph);
    return (ph == PH_DLL) || (ph == PH_HREL) || (ph == PH_SREL);
  endfunction

endpackage

// File: rtl/por_pulse_qual.sv
module por_pulse_qual #(
  parameter int unsigned MIN_LOW = 16
) (
  input  logic clk,
  input  logic por_n,
  output logic por_rise,
  output logic por_accept
);
  localparam int unsigned LEN_W = $clog2(MIN_LOW + 1);

  logic             por_q;
  logic [LEN_W-1:0] low_len;

  always_ff @(posedge clk) begin
    por_q <= por_n;
    if (!por_n) begin
      if (por_q)
        low_len <= LEN_W'(1);
      else if (low_len != LEN_W'(MIN_LOW))
        low_len <= low_len + LEN_W'(1);
    end
  end

  assign por_rise   = por_n && !por_q;
  assign por_accept = por_rise && (low_len >= LEN_W'(MIN_LOW));
endmodule

// File: rtl/pll_prediv.sv
module pll_prediv #(
  parameter int unsigned DIV = 1
) (
  input  logic clk,
  input  logic en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = en;
    end else begin : g_count
      localparam int unsigned DW = $clog2(DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!en || div_q == DW'(DIV - 1))
          div_q <= '0;
        else
          div_q <= div_q + DW'(1);
      end
      assign tick = en && (div_q == DW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/strap_hold.sv
module strap_hold #(
  parameter int unsigned MODE_W = 3
) (
  input  logic              clk,
  input  logic              load,
  input  logic              cfg_sel,
  input  logic [MODE_W-1:0] modck,
  input  logic              dll_dis,
  output logic              cfg_master,
  output logic [MODE_W-1:0] modck_q,
  output logic              dll_off
);
  always_ff @(posedge clk) begin
    if (load) begin
      cfg_master <= cfg_sel;
      modck_q    <= modck;
      dll_off    <= dll_dis;
    end
  end
endmodule

// File: rtl/por_reset_seq.sv
module por_reset_seq
  import por_seq_pkg::*;
#(
  parameter int unsigned MIN_POR_LOW = 16,
  parameter int unsigned CFG_CYC     = 1024,
  parameter int unsigned PLL_PREDIV  = 1,
  parameter int unsigned PLL_CYC     = 800,
  parameter int unsigned DLL_CYC     = 3073,
  parameter int unsigned HREL_CYC    = 512,
  parameter int unsigned SREL_CYC    = 3,
  parameter int unsigned MODE_W      = 3
) (
  input  logic              clk,
  input  logic              bus_ce,
  input  logic              por_n,
  input  logic              cfg_sel,
  input  logic [MODE_W-1:0] modck,
  input  logic              dll_dis,
  output logic              hreset_n,
  output logic              sreset_n,
  output logic              cfg_master,
  output logic [MODE_W-1:0] modck_q,
  output logic              dll_off,
  output logic              pll_locked,
  output logic              dll_locked,
  output logic [2:0]        phase
);
  localparam int unsigned MAX_A  = (CFG_CYC > PLL_CYC) ? CFG_CYC : PLL_CYC;
  localparam int unsigned MAX_B  = (DLL_CYC > HREL_CYC) ? DLL_CYC : HREL_CYC;
  localparam int unsigned MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAXLEN = (MAX_AB > SREL_CYC) ? MAX_AB : SREL_CYC;
  localparam int unsigned CNT_W  = $clog2(MAXLEN + 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  // Named internal events.
  logic por_rise, por_accept;
  logic pll_tick;
  logic step;
  logic phase_done;
  logic in_bus_phase;
  int unsigned cur_len;

  por_pulse_qual #(.MIN_LOW(MIN_POR_LOW)) u_qual (
    .clk       (clk),
    .por_n     (por_n),
    .por_rise  (por_rise),
    .por_accept(por_accept)
  );

  pll_prediv #(.DIV(PLL_PREDIV)) u_prediv (
    .clk (clk),
    .en  (phase_q == PH_PLL),
    .tick(pll_tick)
  );

  strap_hold #(.MODE_W(MODE_W)) u_straps (
    .clk       (clk),
    .load      (por_accept && phase_q == PH_IDLE),
    .cfg_sel   (cfg_sel),
    .modck     (modck),
    .dll_dis   (dll_dis),
    .cfg_master(cfg_master),
    .modck_q   (modck_q),
    .dll_off   (dll_off)
  );

  assign in_bus_phase = is_bus_phase(phase_q);
  assign cur_len      = phase_len(phase_q, CFG_CYC, PLL_CYC, DLL_CYC, HREL_CYC, SREL_CYC);

  always_comb begin
    case (phase_q)
      PH_CFG:                   step = 1'b1;
      PH_PLL:                   step = pll_tick;
      PH_DLL, PH_HREL, PH_SREL: step = bus_ce;
      default:                  step = 1'b0;
    endcase
  end

  assign phase_done = step && (cnt_q == CNT_W'(cur_len - 1));

  always_ff @(posedge clk) begin
    if (!por_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      cnt_q <= '0;
      if (por_accept) phase_q <= PH_CFG;
    end else if (phase_done) begin
      cnt_q   <= '0;
      phase_q <= phase_next(phase_q, dll_off);
    end else if (step) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign hreset_n   = por_n && (phase_q == PH_SREL || phase_q == PH_DONE);
  assign sreset_n   = por_n && (phase_q == PH_DONE);
  assign pll_locked = phase_q inside {PH_DLL, PH_HREL, PH_SREL, PH_DONE};
  assign dll_locked = phase_q inside {PH_HREL, PH_SREL, PH_DONE};
  assign phase      = phase_q;

  // R2: a pulse that was too short leaves the block idle.
  a_r2_short_ignored: assert property (@(posedge clk) disable iff (!por_n)
    (por_rise && !por_accept && phase_q == PH_IDLE) |=> (phase_q == PH_IDLE));

  // R3: latched straps hold still outside idle.
  a_r3_straps_stable: assert property (@(posedge clk) disable iff (!por_n)
    (phase_q != PH_IDLE) |=> $stable({cfg_master, modck_q, dll_off}));

  // R6: a bypassed DLL sends the PLL wait straight to the hard hold.
  a_r6_dll_skip: assert property (@(posedge clk) disable iff (!por_n)
    (phase_q == PH_PLL && phase_done && dll_off) |=> (phase_q == PH_HREL));

  // R7: hard reset only comes out of the hard-release hold.
  a_r7_hard_source: assert property (@(posedge clk) disable iff (!por_n)
    $rose(hreset_n) |-> ($past(phase_q) == PH_HREL));

  // R8: soft reset never leads hard reset.
  a_r8_soft_after_hard: assert property (@(posedge clk) disable iff (!por_n)
    sreset_n |-> hreset_n);

  // R9: bus-clock phases freeze while the enable is low.
  a_r9_bus_gate: assert property (@(posedge clk) disable iff (!por_n)
    (in_bus_phase && !bus_ce) |=> ($stable(cnt_q) && $stable(phase_q)));

endmodule

// File: tb/por_reset_seq_tb.sv
module por_reset_seq_tb;
  // Timing restated from the requirements.
  localparam int CFG_N  = 1024;
  localparam int PLL_N  = 800;
  localparam int DLL_N  = 3073;
  localparam int HREL_N = 512;
  localparam int SREL_N = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic cfg_sel = 1'b0;
  logic [2:0] modck = 3'd0;
  logic dll_dis = 1'b0;
  logic ce_level = 1'b1;
  logic ce_half = 1'b0;
  logic ce_tog = 1'b0;
  logic bus_ce;
  logic hreset_n, sreset_n, cfg_master, dll_off, pll_locked, dll_locked;
  logic [2:0] modck_q, phase;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz
  always @(negedge clk) ce_tog <= ~ce_tog;
  assign bus_ce = ce_half ? ce_tog : ce_level;

  por_reset_seq u_dut (
    .clk(clk), .bus_ce(bus_ce), .por_n(por_n), .cfg_sel(cfg_sel), .modck(modck),
    .dll_dis(dll_dis), .hreset_n(hreset_n), .sreset_n(sreset_n),
    .cfg_master(cfg_master), .modck_q(modck_q), .dll_off(dll_off),
    .pll_locked(pll_locked), .dll_locked(dll_locked), .phase(phase)
  );

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic adv(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Low pulse covering exactly 'edges' rising edges; ends on a falling edge with por_n high.
  task automatic por_pulse(int edges);
    @(negedge clk);
    por_n = 1'b0;
    repeat (edges) @(posedge clk);
    @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic t_reset_state();
    adv(20);
    check("R1 hreset_n in reset", hreset_n, 0);
    check("R1 sreset_n in reset", sreset_n, 0);
    check("R1 phase idle in reset", phase, 0);
  endtask

  task automatic t_full_with_dll();
    cfg_sel = 1'b1; modck = 3'd5; dll_dis = 1'b0; ce_half = 1'b0; ce_level = 1'b1;
    por_pulse(20);
    adv(1);
    check("R4 config entered", phase, 1);
    check("R3 cfg_master latched", cfg_master, 1);
    check("R3 modck latched", modck_q, 5);
    cfg_sel = 1'b0; modck = 3'd2; dll_dis = 1'b1;
    adv(CFG_N - 1);
    check("R4 config last cycle", phase, 1);
    adv(1);
    check("R5 PLL wait entered", phase, 2);
    check("R5 pll_locked low during wait", pll_locked, 0);
    adv(PLL_N - 1);
    check("R5 PLL wait last cycle", phase, 2);
    adv(1);
    check("R6 DLL wait entered", phase, 3);
    check("R5 pll_locked after wait", pll_locked, 1);
    check("R3 modck held during run", modck_q, 5);
    check("R3 dll_off held during run", dll_off, 0);
    adv(DLL_N - 1);
    check("R6 DLL wait last cycle", phase, 3);
    check("R6 dll_locked low in wait", dll_locked, 0);
    adv(1);
    check("R6 hard hold after DLL", phase, 4);
    check("R6 dll_locked after wait", dll_locked, 1);
    adv(HREL_N - 1);
    check("R7 hreset_n still low", hreset_n, 0);
    check("R1 sreset_n still low", sreset_n, 0);
    adv(1);
    check("R7 hreset_n released", hreset_n, 1);
    check("R7 soft hold entered", phase, 5);
    check("R8 sreset_n low at hard release", sreset_n, 0);
    adv(SREL_N - 1);
    check("R8 sreset_n low before gap end", sreset_n, 0);
    adv(1);
    check("R8 sreset_n released after 3", sreset_n, 1);
    check("R8 done phase", phase, 6);
  endtask

  task automatic t_skip_dll_half_rate();
    int n;
    cfg_sel = 1'b0; modck = 3'd2; dll_dis = 1'b1; ce_half = 1'b0; ce_level = 1'b1;
    por_pulse(16);
    adv(1);
    check("R2 16-edge pulse accepted", phase, 1);
    check("R3 new modck latched", modck_q, 2);
    check("R3 dll_off latched", dll_off, 1);
    adv(CFG_N + PLL_N);
    check("R6 DLL skipped to hard hold", phase, 4);
    check("R6 dll_locked when bypassed", dll_locked, 1);
    ce_level = 1'b0;
    adv(40);
    check("R9 phase frozen without bus_ce", phase, 4);
    check("R9 hreset_n held without bus_ce", hreset_n, 0);
    ce_half = 1'b1;
    n = 0;
    while (!hreset_n && n < 4000) begin adv(1); n++; end
    check("R7 hard release reached", hreset_n, 1);
    check("R9 half-rate hold length", (n >= 2 * HREL_N - 2 && n <= 2 * HREL_N + 1) ? 1 : 0, 1);
    n = 0;
    while (!sreset_n && n < 50) begin adv(1); n++; end
    check("R8 R9 soft gap at half rate", n, 2 * SREL_N);
    ce_half = 1'b0; ce_level = 1'b1;
  endtask

  task automatic t_short_pulse();
    cfg_sel = 1'b1; modck = 3'd7; dll_dis = 1'b0;
    @(negedge clk);
    por_n = 1'b0;
    #1;
    check("R1 hreset_n drops with por_n", hreset_n, 0);
    check("R1 sreset_n drops with por_n", sreset_n, 0);
    repeat (15) @(posedge clk);
    @(negedge clk);
    por_n = 1'b1;
    adv(1);
    check("R2 15-edge pulse rejected", phase, 0);
    adv(20);
    check("R2 still idle", phase, 0);
    check("R2 hreset_n low after reject", hreset_n, 0);
    check("R2 straps kept cfg", cfg_master, 0);
    check("R2 straps kept modck", modck_q, 2);
  endtask

  task automatic t_abort_mid_run();
    cfg_sel = 1'b1; modck = 3'd7; dll_dis = 1'b0;
    por_pulse(16);
    adv(1);
    check("R3 modck after accept", modck_q, 7);
    adv(CFG_N + PLL_N + 100);
    check("R6 in DLL wait before abort", phase, 3);
    @(negedge clk);
    por_n = 1'b0;
    #1;
    check("R1 hreset_n low on abort", hreset_n, 0);
    adv(1);
    check("R1 idle after abort", phase, 0);
    check("R1 sreset_n low after abort", sreset_n, 0);
  endtask

  initial begin
    t_reset_state();
    t_full_with_dll();
    t_skip_dll_half_rate();
    t_short_pulse();
    t_abort_mid_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule